// File: doc/BRIEF.md
# Half-Precision Value Class Tester

This block inspects the lowest 16-bit half-precision element of a wider source word and reports whether it falls into any of a programmable set of special-value categories. An 8-bit selector chooses which categories count. The block tests every enabled category, combines the hits into one boolean, and writes that boolean to bit 0 of a mask-width result word. All higher bits of the result are cleared.

An optional writemask can suppress the result. When the writemask is in use and its bit is clear, bit 0 of the result is forced to zero. When the writemask is not in use, its bit has no effect. Each accepted request produces one registered result exactly one cycle later. The block raises no exception indication for any input, and that includes signalling NaNs.

Top module: `hpc_class_tester`

## Requirements
- R1: Only source bits 15:0 are classified. They are read as sign in bit 15, exponent in bits 14:10 and fraction in bits 9:0. Source bits above bit 15 never change the result.
- R2: NaN means exponent 5'h1F with a nonzero fraction. Selector bit 0 picks quiet NaN, which has fraction bit 9 set. Selector bit 7 picks signalling NaN, which has fraction bit 9 clear.
- R3: Selector bit 1 picks +0 (16'h0000) and selector bit 2 picks -0 (16'h8000).
- R4: Selector bit 3 picks +infinity (16'h7C00) and selector bit 4 picks -infinity (16'hFC00).
- R5: Selector bit 5 picks denormals, meaning exponent zero with a nonzero fraction, of either sign.
- R6: Selector bit 6 picks finite negatives. This is any value with sign set that is neither NaN nor infinity, so it includes -0 and negative denormals.
- R7: The result bit is the OR of the hits of the enabled categories only. A selector of 8'h00 always gives 0, and a positive normal value always gives 0.
- R8: When the writemask-enable input is 1 and the writemask bit is 0, result bit 0 is 0. When the writemask-enable input is 0, the writemask bit has no effect.
- R9: Result bits MASK_W-1 down to 1 are always 0.
- R10: Reset clears out_valid and out_mask. out_valid is high exactly in the cycle after in_valid was high. out_mask holds its value when no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_src | input | SRC_W | Source word; only bits 15:0 are classified |
| in_imm | input | 8 | Category selector, one bit per category |
| in_wm_en | input | 1 | Writemask in use |
| in_wm_bit | input | 1 | Writemask bit 0 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_mask | output | MASK_W | Result mask; only bit 0 can be set |

## Verification
The bound assertions check several rules on every cycle: that the upper result bits stay zero, the one-cycle valid timing, that the result holds while idle, writemask suppression, and that a zero selector or a positive normal input never yields a hit. Signalling-NaN detection is also tied to its selector bit. Only the bench's scenarios can show the per-category mapping of each selector bit, that quiet and signalling NaNs are told apart, which values count as finite negatives, and that upper source bits are ignored. The bench covers these with directed values and a randomized sweep that it compares against its own model.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int HALF_W = 16;
  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int NCAT   = 8;

  // selector bit positions (behavioural: the selector decodes them)
  localparam int CAT_QNAN  = 0;
  localparam int CAT_PZERO = 1;
  localparam int CAT_NZERO = 2;
  localparam int CAT_PINF  = 3;
  localparam int CAT_NINF  = 4;
  localparam int CAT_DENOM = 5;
  localparam int CAT_FNEG  = 6;
  localparam int CAT_SNAN  = 7;

  typedef logic [NCAT-1:0] cat_vec_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } half_t;

  typedef struct packed {
    logic sign;
    logic exp_max;
    logic exp_zero;
    logic frac_zero;
    logic frac_top;
  } half_flags_t;
endpackage

// File: rtl/hpc_field_split.sv
module hpc_field_split
  import hpc_pkg::*;
#(
  parameter int SRC_W = 128
) (
  input  logic [SRC_W-1:0] src,
  output half_flags_t      flags
);
  half_t h;

  assign h = half_t'(src[HALF_W-1:0]);

  generate
    if (SRC_W > HALF_W) begin : g_wide
      logic unused_upper;
      assign unused_upper = ^src[SRC_W-1:HALF_W];
    end
  endgenerate

  always_comb begin
    flags.sign      = h.sign;
    flags.exp_max   = &h.expo;
    flags.exp_zero  = ~|h.expo;
    flags.frac_zero = ~|h.frac;
    flags.frac_top  = h.frac[FRAC_W-1];
  end
endmodule

// File: rtl/hpc_category_detect.sv
module hpc_category_detect
  import hpc_pkg::*;
(
  input  half_flags_t flags,
  output cat_vec_t    hits
);
  logic is_nan, is_inf, is_zero, is_den;

  always_comb begin
    is_nan  = flags.exp_max & ~flags.frac_zero;
    is_inf  = flags.exp_max &  flags.frac_zero;
    is_zero = flags.exp_zero & flags.frac_zero;
    is_den  = flags.exp_zero & ~flags.frac_zero;

    hits            = '0;
    hits[CAT_QNAN]  = is_nan &  flags.frac_top;
    hits[CAT_SNAN]  = is_nan & ~flags.frac_top;
    hits[CAT_PZERO] = is_zero & ~flags.sign;
    hits[CAT_NZERO] = is_zero &  flags.sign;
    hits[CAT_PINF]  = is_inf  & ~flags.sign;
    hits[CAT_NINF]  = is_inf  &  flags.sign;
    hits[CAT_DENOM] = is_den;
    hits[CAT_FNEG]  = flags.sign & ~flags.exp_max;
  end
endmodule

// File: rtl/hpc_select_combine.sv
module hpc_select_combine
  import hpc_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input  cat_vec_t          hits,
  input  logic [NCAT-1:0]   sel,
  input  logic              wm_en,
  input  logic              wm_bit,
  output logic [MASK_W-1:0] mask_next
);
  logic [NCAT-1:0] gated;
  logic            any_hit;
  logic            allow;

  genvar gi;
  generate
    for (gi = 0; gi < NCAT; gi++) begin : g_gate
      assign gated[gi] = hits[gi] & sel[gi];
    end
  endgenerate

  assign any_hit = |gated;
  assign allow   = ~wm_en | wm_bit;

  always_comb begin
    mask_next    = '0;
    mask_next[0] = any_hit & allow;
  end
endmodule

// File: rtl/hpc_class_tester.sv
module hpc_class_tester
  import hpc_pkg::*;
#(
  parameter int SRC_W  = 128,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [7:0]        in_imm,
  input  logic              in_wm_en,
  input  logic              in_wm_bit,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask
);
  half_flags_t       flags;
  cat_vec_t          hits;
  logic [MASK_W-1:0] mask_next;

  hpc_field_split #(.SRC_W(SRC_W)) u_split (
    .src   (in_src),
    .flags (flags)
  );

  hpc_category_detect u_detect (
    .flags (flags),
    .hits  (hits)
  );

  hpc_select_combine #(.MASK_W(MASK_W)) u_comb (
    .hits      (hits),
    .sel       (in_imm),
    .wm_en     (in_wm_en),
    .wm_bit    (in_wm_bit),
    .mask_next (mask_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= mask_next;
    end
  end
endmodule

// File: rtl/hpc_class_tester_chk.sv
module hpc_class_tester_chk #(
  parameter int SRC_W  = 128,
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SRC_W-1:0]  in_src,
  input logic [7:0]        in_imm,
  input logic              in_wm_en,
  input logic              in_wm_bit,
  input logic              out_valid,
  input logic [MASK_W-1:0] out_mask
);
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    out_mask[MASK_W-1:1] == '0);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_mask));

  p_wm_block_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_wm_en && !in_wm_bit) |=> !out_mask[0]);

  p_sel_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_imm == 8'h00) |=> !out_mask[0]);

  p_pos_normal_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_src[15] && in_src[14:10] != 5'h00 && in_src[14:10] != 5'h1F)
    |=> !out_mask[0]);

  p_snan_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wm_en && in_imm == 8'h80 && in_src[14:10] == 5'h1F &&
     !in_src[9] && in_src[8:0] != 9'h000) |=> out_mask[0]);
endmodule

bind hpc_class_tester hpc_class_tester_chk #(.SRC_W(SRC_W), .MASK_W(MASK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_src    (in_src),
  .in_imm    (in_imm),
  .in_wm_en  (in_wm_en),
  .in_wm_bit (in_wm_bit),
  .out_valid (out_valid),
  .out_mask  (out_mask)
);

// File: tb/tb_hpc_class_tester.sv
module tb_hpc_class_tester;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_W      = 128;
  localparam int MASK_W     = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [SRC_W-1:0]  in_src;
  logic [7:0]        in_imm;
  logic              in_wm_en;
  logic              in_wm_bit;
  logic              out_valid;
  logic [MASK_W-1:0] out_mask;

  int checks = 0;
  int errors = 0;
  logic [MASK_W-1:0] exp_q[$];
  string             tag_q[$];
  logic [MASK_W-1:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpc_class_tester #(.SRC_W(SRC_W), .MASK_W(MASK_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_imm(in_imm), .in_wm_en(in_wm_en), .in_wm_bit(in_wm_bit),
    .out_valid(out_valid), .out_mask(out_mask)
  );

  // Reference model written from the requirements
  function automatic logic model(input logic [15:0] h, input logic [7:0] sel,
                                 input logic wen, input logic wb);
    logic       s;
    logic [4:0] e;
    logic [9:0] f;
    logic       nan, inf, zer, den;
    logic [7:0] cat;
    s = h[15]; e = h[14:10]; f = h[9:0];
    nan = (e == 5'h1F) && (f != 0);
    inf = (e == 5'h1F) && (f == 0);
    zer = (e == 0) && (f == 0);
    den = (e == 0) && (f != 0);
    cat[0] = nan && f[9];
    cat[7] = nan && !f[9];
    cat[1] = zer && !s;
    cat[2] = zer && s;
    cat[3] = inf && !s;
    cat[4] = inf && s;
    cat[5] = den;
    cat[6] = s && !nan && !inf;
    return (|(cat & sel)) && (!wen || wb);
  endfunction

  task automatic check(input string tag, input logic [MASK_W-1:0] act,
                       input logic [MASK_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(input string tag, input logic [SRC_W-1:0] src,
                      input logic [7:0] sel, input logic wen, input logic wb);
    logic [MASK_W-1:0] e;
    @(negedge clk);
    in_valid  = 1'b1;
    in_src    = src;
    in_imm    = sel;
    in_wm_en  = wen;
    in_wm_bit = wb;
    e = '0;
    e[0] = model(src[15:0], sel, wen, wb);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_src   = {SRC_W{1'b1}};
      in_imm   = 8'hFF;
    end
  endtask

  function automatic logic [SRC_W-1:0] junk(input logic [15:0] lo);
    logic [SRC_W-1:0] v;
    for (int i = 0; i < SRC_W/32; i++) v[i*32 +: 32] = $urandom;
    v[15:0] = lo;
    return v;
  endfunction

  // Monitor: pops one expected item per result strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected out_valid, actual 1 expected 0");
      end else begin
        check(tag_q.pop_front(), out_mask, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_imm = '0;
    in_wm_en = 1'b0; in_wm_bit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset valid", {{(MASK_W-1){1'b0}}, out_valid}, '0);
    check("R10 reset mask", out_mask, '0);
    rst = 1'b0;

    // R3 zeros
    send("R3 +0 sel1", junk(16'h0000), 8'h02, 0, 0);
    send("R3 +0 sel2", junk(16'h0000), 8'h04, 0, 0);
    send("R3 -0 sel2", junk(16'h8000), 8'h04, 0, 0);
    send("R3 -0 sel1", junk(16'h8000), 8'h02, 0, 0);
    // R4 infinities
    send("R4 +inf sel3", junk(16'h7C00), 8'h08, 0, 0);
    send("R4 +inf sel4", junk(16'h7C00), 8'h10, 0, 0);
    send("R4 -inf sel4", junk(16'hFC00), 8'h10, 0, 0);
    // R2 NaNs
    send("R2 qnan sel0", junk(16'h7E00), 8'h01, 0, 0);
    send("R2 qnan sel7", junk(16'h7E00), 8'h80, 0, 0);
    send("R2 snan sel7", junk(16'h7C01), 8'h80, 0, 0);
    send("R2 snan sel0", junk(16'h7C01), 8'h01, 0, 0);
    // R5 denormals
    send("R5 +den", junk(16'h0001), 8'h20, 0, 0);
    send("R5 -den", junk(16'h8200), 8'h20, 0, 0);
    // R6 finite negative
    send("R6 -0", junk(16'h8000), 8'h40, 0, 0);
    send("R6 -den", junk(16'h8200), 8'h40, 0, 0);
    send("R6 -1.0", junk(16'hBC00), 8'h40, 0, 0);
    send("R6 -inf excluded", junk(16'hFC00), 8'h40, 0, 0);
    send("R6 -nan excluded", junk(16'hFD00), 8'h40, 0, 0);
    // R7 combining
    send("R7 +1.0 all", junk(16'h3C00), 8'hFF, 0, 0);
    send("R7 -1.0 all but fneg", junk(16'hBC00), 8'hBF, 0, 0);
    send("R7 sel zero", junk(16'h8000), 8'h00, 0, 0);
    // R8 writemask
    send("R8 wm blocks", junk(16'h0000), 8'h02, 1, 0);
    send("R8 wm passes", junk(16'h0000), 8'h02, 1, 1);
    send("R8 wm unused", junk(16'h0000), 8'h02, 0, 0);
    // R1 upper bits ignored
    send("R1 high ones +1", {{(SRC_W-16){1'b1}}, 16'h3C00}, 8'hFF, 0, 0);
    send("R1 high ones +0", {{(SRC_W-16){1'b1}}, 16'h0000}, 8'h02, 0, 0);
    idle(1);

    // R10 hold while idle, and result flow drained
    send("R10 hold seed", junk(16'hFC00), 8'h10, 0, 0);
    idle(4);
    check("R10 hold mask", out_mask, last_exp);
    check("R10 idle valid", {{(MASK_W-1){1'b0}}, out_valid}, '0);

    // Randomized sweep, R9 upper bits compared within each item
    for (int k = 0; k < 300; k++) begin
      logic [15:0] h;
      h = $urandom;
      if (k % 4 == 0) h[14:10] = 5'h1F;
      if (k % 4 == 1) h[14:10] = 5'h00;
      send("R9 random", junk(h), 8'($urandom), 1'($urandom), 1'($urandom));
      if (k % 7 == 0) idle(1);
    end
    idle(3);
    check("R10 queue drained", 64'(exp_q.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule